// File: doc/BRIEF.md
# DRAM Clock-Enable Power-State Controller

This block follows the power state of a synchronous graphics DRAM as the controller moves its clock-enable pin. Every cycle it sees two clock-enable levels: the one the device saw last cycle and the one it sees now. It also sees the command strobes (select, row strobe, column strobe, write strobe and the special-function strobe) and a flag from the bank tracker that is high when every bank is idle. From these it keeps one of four states: normal, power down, self refresh or clock suspend. It also reports the action that the cycle implies.

A falling clock enable with all banks idle and a deselect or no-operation command enters power down. The self-refresh command enters self refresh. With any bank open, a falling clock enable only suspends the clock. Both low-power states are left by a rising clock enable that carries a deselect or no-operation command. Any other command on that rising edge is flagged as illegal and leaves the state unchanged. After a self-refresh exit, a row-cycle lockout holds a command-blocked flag for a parameterised number of cycles.

All outputs are registered, so the response to a sampled cycle appears one clock later.

Top module: `dram_lowpower_ctrl`

## Requirements
- R1: Synchronous active-high reset sets the state to normal (code 0), the action to 0, and both the illegal and blocked flags low.
- R2: When the previous and current clock-enable levels are equal, the state does not change. With both levels low in power down or self refresh, the action is hold-low-power (6). In suspend it is hold-suspend (9). In normal it is no-op (0).
- R3: In normal state with all banks idle, a previous-high/current-low clock enable with select high (deselect) or with select low and row, column and write strobes all high (no-op) moves to power down (code 1), with action 2.
- R4: In normal state with all banks idle, a previous-high/current-low clock enable with select, row and column strobes low, write strobe high and the special-function strobe low moves to self refresh (code 2), with action 3.
- R5: In normal state with any bank not idle, a previous-high/current-low clock enable moves to clock suspend (code 3), with action 7. In suspend, a previous-low/current-high pair returns to normal with action 8.
- R6: In power down or self refresh, a previous-low/current-high clock enable with a deselect or no-op command returns to normal. The action is 4 from power down and 5 from self refresh. Any other command on that edge is flagged illegal and the state stays put. A previous-high clock enable in these states gives action 13 (inconsistent) with no change.
- R7: A self-refresh exit raises the blocked flag in the next cycle and holds it for exactly TRC_CYC cycles. Every exit reloads the full count.
- R8: In normal state with all banks idle and both clock-enable levels high, select, row, column and write strobes all low decode as mode-register access (action 10) when the special-function strobe is low, and as special mode-register access (action 11) when it is high. Any other command in that case decodes as pass-to-command-table (action 1).
- R9: A falling clock enable in normal state with all banks idle and a command that is neither deselect, no-op nor self refresh is illegal. The illegal flag is a one-cycle registered pulse per offending cycle, the action is 12, and the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clken_prev | input | 1 | Clock-enable level of the previous cycle |
| clken_now | input | 1 | Clock-enable level of the current cycle |
| sel_n | input | 1 | Chip select, active low |
| row_stb_n | input | 1 | Row address strobe, active low |
| col_stb_n | input | 1 | Column address strobe, active low |
| wr_stb_n | input | 1 | Write strobe, active low |
| spec_fn | input | 1 | Special-function strobe |
| banks_idle | input | 1 | High when every bank is idle |
| pwr_state | output | 2 | 0 normal, 1 power down, 2 self refresh, 3 clock suspend |
| illegal | output | 1 | One-cycle pulse for an illegal command |
| cmd_blocked | output | 1 | High during the self-refresh exit lockout |
| action | output | 4 | Decoded action code |

## Verification
The bench builds the block with TRC_CYC set to 5. This keeps the whole lockout window short enough to be checked cycle by cycle, and it exposes an off-by-one at either end of the window. A second exit made while an earlier count is still running shows whether the counter is reloaded or just left to run out. The vector table carries the state across rows, so every transition is reached from a state set up by an earlier row.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [1:0] {
    PS_NORMAL = 2'd0,
    PS_PDOWN  = 2'd1,
    PS_SREF   = 2'd2,
    PS_SUSP   = 2'd3
  } pstate_e;

  typedef enum logic [3:0] {
    ACT_NOP        = 4'd0,
    ACT_TABLE      = 4'd1,
    ACT_ENTER_PD   = 4'd2,
    ACT_ENTER_SR   = 4'd3,
    ACT_EXIT_PD    = 4'd4,
    ACT_EXIT_SR    = 4'd5,
    ACT_HOLD_LP    = 4'd6,
    ACT_SUSP_BEGIN = 4'd7,
    ACT_SUSP_END   = 4'd8,
    ACT_SUSP_HOLD  = 4'd9,
    ACT_MODE_WR    = 4'd10,
    ACT_SPMODE_WR  = 4'd11,
    ACT_ILLEGAL    = 4'd12,
    ACT_INVALID    = 4'd13
  } act_e;

  typedef struct packed {
    logic desel;
    logic nop;
    logic sref_cmd;
    logic mode_wr;
    logic spmode_wr;
  } cmd_cls_t;

endpackage

// File: rtl/lp_cmd_class.sv
module lp_cmd_class
  import lp_pkg::*;
(
  input  logic     sel_n,
  input  logic     row_stb_n,
  input  logic     col_stb_n,
  input  logic     wr_stb_n,
  input  logic     spec_fn,
  output cmd_cls_t cls
);

  logic [2:0] strobes;
  assign strobes = {row_stb_n, col_stb_n, wr_stb_n};

  always_comb begin
    cls           = '0;
    cls.desel     = sel_n;
    cls.nop       = !sel_n && (strobes == 3'b111);
    cls.sref_cmd  = !sel_n && (strobes == 3'b001) && !spec_fn;
    cls.mode_wr   = !sel_n && (strobes == 3'b000) && !spec_fn;
    cls.spmode_wr = !sel_n && (strobes == 3'b000) && spec_fn;
  end

  // R3: a command can be no more than one of deselect and no-op
  always_comb begin
    a_r3_cls_exclusive: assert ($onehot0({cls.desel, cls.nop, cls.sref_cmd, cls.mode_wr, cls.spmode_wr}));
  end

endmodule

// File: rtl/lp_state_fsm.sv
module lp_state_fsm
  import lp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clken_prev,
  input  logic     clken_now,
  input  logic     banks_idle,
  input  cmd_cls_t cls,
  output pstate_e  state,
  output act_e     action,
  output logic     illegal,
  output logic     sr_exit
);

  pstate_e    nxt;
  act_e       act_c;
  logic       bad_c;
  logic [1:0] pair;
  logic       quiet;

  assign pair  = {clken_prev, clken_now};
  assign quiet = cls.desel || cls.nop;

  always_comb begin
    nxt     = state;
    act_c   = ACT_NOP;
    bad_c   = 1'b0;
    sr_exit = 1'b0;
    case (state)
      PS_NORMAL: begin
        case (pair)
          2'b11: begin
            if (banks_idle && cls.mode_wr)        act_c = ACT_MODE_WR;
            else if (banks_idle && cls.spmode_wr) act_c = ACT_SPMODE_WR;
            else                                  act_c = ACT_TABLE;
          end
          2'b10: begin
            if (!banks_idle) begin
              nxt   = PS_SUSP;
              act_c = ACT_SUSP_BEGIN;
            end else if (quiet) begin
              nxt   = PS_PDOWN;
              act_c = ACT_ENTER_PD;
            end else if (cls.sref_cmd) begin
              nxt   = PS_SREF;
              act_c = ACT_ENTER_SR;
            end else begin
              bad_c = 1'b1;
              act_c = ACT_ILLEGAL;
            end
          end
          default: act_c = ACT_NOP;
        endcase
      end
      PS_PDOWN, PS_SREF: begin
        case (pair)
          2'b00: act_c = ACT_HOLD_LP;
          2'b01: begin
            if (quiet) begin
              nxt     = PS_NORMAL;
              sr_exit = (state == PS_SREF);
              act_c   = (state == PS_SREF) ? ACT_EXIT_SR : ACT_EXIT_PD;
            end else begin
              bad_c = 1'b1;
              act_c = ACT_ILLEGAL;
            end
          end
          default: act_c = ACT_INVALID;
        endcase
      end
      default: begin
        case (pair)
          2'b01: begin
            nxt   = PS_NORMAL;
            act_c = ACT_SUSP_END;
          end
          2'b11:   act_c = ACT_TABLE;
          default: act_c = ACT_SUSP_HOLD;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PS_NORMAL;
      action  <= ACT_NOP;
      illegal <= 1'b0;
    end else begin
      state   <= nxt;
      action  <= act_c;
      illegal <= bad_c;
    end
  end

  // R2: equal clock-enable levels never move the state
  a_r2_equal_pair_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(clken_prev) == $past(clken_now))) |-> (state == $past(state)));

  // R9: an illegal command leaves the state unchanged
  a_r9_illegal_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && illegal) |-> (state == $past(state)));

  // R3 / R4: low-power entry only with all banks idle
  a_r3_lp_entry_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(state) == PS_NORMAL && (state == PS_PDOWN || state == PS_SREF))
      |-> $past(banks_idle));

  // R5: suspend entered only on a falling clock enable with open banks
  a_r5_susp_entry: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(state) == PS_NORMAL && state == PS_SUSP)
      |-> ($past(clken_prev) && !$past(clken_now) && !$past(banks_idle)));

endmodule

// File: rtl/lp_exit_lockout.sv
module lp_exit_lockout #(
  parameter int TRC_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic blocked
);

  localparam int CNT_W = (TRC_CYC < 2) ? 1 : $clog2(TRC_CYC + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TRC_CYC);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (load)          cnt_nxt = FULL;
    else if (cnt != 0) cnt_nxt = cnt - 1'b1;
    else               cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      blocked <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      blocked <= (cnt_nxt != 0);
    end
  end

  // R7: every exit reloads the full window
  a_r7_reload: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == FULL));

  // R7: the window counts down by one per cycle
  a_r7_countdown: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != 0) |=> (cnt == $past(cnt) - 1'b1));

  // R7: the count never exceeds the lockout length
  a_r7_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

endmodule

// File: rtl/dram_lowpower_ctrl.sv
module dram_lowpower_ctrl
  import lp_pkg::*;
#(
  parameter int TRC_CYC = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clken_prev,
  input  logic       clken_now,
  input  logic       sel_n,
  input  logic       row_stb_n,
  input  logic       col_stb_n,
  input  logic       wr_stb_n,
  input  logic       spec_fn,
  input  logic       banks_idle,
  output logic [1:0] pwr_state,
  output logic       illegal,
  output logic       cmd_blocked,
  output logic [3:0] action
);

  cmd_cls_t cls;
  pstate_e  st;
  act_e     act;
  logic     sr_exit;

  lp_cmd_class u_class (
    .sel_n     (sel_n),
    .row_stb_n (row_stb_n),
    .col_stb_n (col_stb_n),
    .wr_stb_n  (wr_stb_n),
    .spec_fn   (spec_fn),
    .cls       (cls)
  );

  lp_state_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .clken_prev (clken_prev),
    .clken_now  (clken_now),
    .banks_idle (banks_idle),
    .cls        (cls),
    .state      (st),
    .action     (act),
    .illegal    (illegal),
    .sr_exit    (sr_exit)
  );

  lp_exit_lockout #(.TRC_CYC(TRC_CYC)) u_lock (
    .clk     (clk),
    .rst     (rst),
    .load    (sr_exit),
    .blocked (cmd_blocked)
  );

  assign pwr_state = st;
  assign action    = act;

  // R7: the lockout starts only on the cycle after leaving self refresh
  a_r7_block_after_sr: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_blocked) |-> ($past(st) == PS_SREF && st == PS_NORMAL));

  // R6: leaving a low-power state always lands in normal
  a_r6_exit_to_normal: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(st) == PS_PDOWN || $past(st) == PS_SREF) && st != $past(st))
      |-> (st == PS_NORMAL));

endmodule

// File: tb/tb_dram_lowpower_ctrl.sv
module tb_dram_lowpower_ctrl;

  localparam int TRC = 5;
  localparam int NV  = 17;

  logic clk = 1'b0;
  logic rst;
  logic clken_prev, clken_now, sel_n, row_stb_n, col_stb_n, wr_stb_n, spec_fn, banks_idle;
  logic [1:0] pwr_state;
  logic       illegal, cmd_blocked;
  logic [3:0] action;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dram_lowpower_ctrl #(.TRC_CYC(TRC)) dut (
    .clk(clk), .rst(rst), .clken_prev(clken_prev), .clken_now(clken_now),
    .sel_n(sel_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_stb_n(wr_stb_n), .spec_fn(spec_fn), .banks_idle(banks_idle),
    .pwr_state(pwr_state), .illegal(illegal), .cmd_blocked(cmd_blocked),
    .action(action)
  );

  // stimulus {prev, now, sel_n, row, col, wr, spec, idle}, expected state, illegal, action
  localparam logic [14:0] VEC [NV] = '{
    {8'b11011101, 2'd0, 1'b0, 4'd1},   // R8 no-op passes to table
    {8'b11000001, 2'd0, 1'b0, 4'd10},  // R8 mode register
    {8'b11000011, 2'd0, 1'b0, 4'd11},  // R8 special mode register
    {8'b11000000, 2'd0, 1'b0, 4'd1},   // R8 banks busy: table
    {8'b10111101, 2'd1, 1'b0, 4'd2},   // R3 deselect enters power down
    {8'b00111101, 2'd1, 1'b0, 4'd6},   // R2 hold
    {8'b01001101, 2'd1, 1'b1, 4'd12},  // R6 bad exit command
    {8'b01011101, 2'd0, 1'b0, 4'd4},   // R6 no-op exit
    {8'b10011100, 2'd3, 1'b0, 4'd7},   // R5 suspend begins
    {8'b00011100, 2'd3, 1'b0, 4'd9},   // R2 suspend hold
    {8'b01011100, 2'd0, 1'b0, 4'd8},   // R5 suspend ends
    {8'b10011001, 2'd0, 1'b1, 4'd12},  // R9 illegal entry command
    {8'b10011101, 2'd1, 1'b0, 4'd2},   // R3 no-op enters power down
    {8'b01111101, 2'd0, 1'b0, 4'd4},   // R6 deselect exit
    {8'b10000111, 2'd0, 1'b1, 4'd12},  // R9 refresh with spec high
    {8'b10000100, 2'd3, 1'b0, 4'd7},   // R5 refresh cmd, banks busy
    {8'b01000100, 2'd0, 1'b0, 4'd8}    // R5 leave suspend
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic step(input logic [7:0] v);
    {clken_prev, clken_now, sel_n, row_stb_n, col_stb_n, wr_stb_n, spec_fn, banks_idle} = v;
    @(negedge clk);
  endtask

  task automatic expect_all(input string req, input int st, input int ill, input int act, input int blk);
    chk(req, "state", int'(pwr_state), st);
    chk(req, "illegal", int'(illegal), ill);
    chk(req, "action", int'(action), act);
    chk(req, "blocked", int'(cmd_blocked), blk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    {clken_prev, clken_now, sel_n, row_stb_n, col_stb_n, wr_stb_n, spec_fn, banks_idle} = 8'b11111101;
    @(negedge clk);
    @(negedge clk);
    expect_all("R1", 0, 0, 0, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14:7]);
      chk("R10", $sformatf("vec%0d state", i), int'(pwr_state), int'(VEC[i][6:5]));
      chk("R9",  $sformatf("vec%0d illegal", i), int'(illegal), int'(VEC[i][4]));
      chk("R10", $sformatf("vec%0d action", i), int'(action), int'(VEC[i][3:0]));
    end

    // R2: both low in normal is a no-op
    step(8'b00111101);
    expect_all("R2", 0, 0, 0, 0);

    // R4: self refresh entry, hold, inconsistent and bad exits
    step(8'b10000101);
    expect_all("R4", 2, 0, 3, 0);
    step(8'b00111101);
    expect_all("R2", 2, 0, 6, 0);
    step(8'b11111101);
    expect_all("R6", 2, 0, 13, 0);
    step(8'b01011001);
    expect_all("R6", 2, 1, 12, 0);

    // R7: exit and full lockout window
    step(8'b01011101);
    expect_all("R7", 0, 0, 5, 1);
    for (int j = 1; j <= TRC; j++) begin
      step(8'b11111101);
      chk("R7", $sformatf("window j=%0d", j), int'(cmd_blocked), (j < TRC) ? 1 : 0);
    end

    // R7: a second exit reloads the full count
    step(8'b10000101);
    step(8'b01011101);
    chk("R7", "second exit blocked", int'(cmd_blocked), 1);
    step(8'b11111101);
    step(8'b10000101);
    step(8'b01111101);
    chk("R7", "reload state", int'(pwr_state), 0);
    for (int j = 1; j <= TRC; j++) begin
      step(8'b11111101);
      chk("R7", $sformatf("reload j=%0d", j), int'(cmd_blocked), (j < TRC) ? 1 : 0);
    end

    // R1: reset from power down
    step(8'b10111101);
    chk("R3", "pd before reset", int'(pwr_state), 1);
    rst = 1'b1;
    step(8'b00111101);
    expect_all("R1", 0, 0, 0, 0);
    rst = 1'b0;
    step(8'b11111101);
    expect_all("R1", 0, 0, 1, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule